// File: doc/BRIEF.md
# Queued Serial Peripheral Interface Master

This block is a master-side SPI engine that works through a host-built list of up to sixteen transfers without further host help. Each list slot combines an 8-bit command, a 16-bit outgoing word and a 16-bit incoming word. The command gives the chip-select levels for that slot, the transfer length (16 or 8 bits), an optional pause after the transfer, and whether the selects stay driven into the next slot. The host fills the command and outgoing words through a single-cycle write port. It programs a first-slot and a last-slot pointer, a clock divider and an idle select pattern. A write that sets the enable bit then starts the run.

The engine visits the slots in ascending order, wrapping from 15 back to 0, and stops after the last-slot pointer. For each slot it drives SCK (low when idle, MOSI changed while SCK is low, MISO sampled on SCK rising, MSB first) and stores the received word into that slot. It also records the slot index as the completed pointer. After the last slot it sets a sticky done flag, which the host clears by writing one, and drives an interrupt when that is enabled. Clearing enable during a run lets the current slot finish and then returns to idle without setting done.

The sequencer has five states. **IDLE** drives the idle pattern. **LOAD** takes the slot command and starts the shifter. **SHIFT** waits for the last bit. **PAUSE** is the optional 8-cycle post-transfer delay. **GAP** is one cycle of idle pattern between slots. The transitions are as follows:
- IDLE to LOAD on a start write.
- LOAD to SHIFT always.
- SHIFT to PAUSE when the delay bit is set.
- SHIFT or PAUSE to IDLE after the last slot or when enable is clear.
- SHIFT or PAUSE to LOAD when the keep bit is set, otherwise to GAP.
- GAP to LOAD always.

Top module: `spq_master`

## Requirements
- R1: After reset, sel = 4'hF, sclk = 0, irq = 0, and the status word (0x34) reads 0.
- R2: Host word addresses are laid out as follows:
  - 0x00+n is command n.
  - 0x10+n is outgoing word n.
  - 0x20+n is incoming word n (read only).
  - 0x30 is control: bit0 enable, bit1 interrupt enable.
  - 0x31 holds the pointers: bits[3:0] first slot, bits[7:4] last slot.
  - 0x32 is the divider.
  - 0x33 is the idle pattern, bits[3:0].
  - 0x34 is status: bit0 done, bits[7:4] completed pointer.
  - All writable locations read back what was written.
- R3: A run visits slots from the first pointer up to and including the last pointer, incrementing modulo 16. Slots outside that range keep their incoming word.
- R4: Incoming word n holds the MISO bits sampled on SCK rising edges, MSB first. Command bit4 = 1 selects 8 bits: outgoing bits[7:0] are sent and the result sits in bits[7:0] with bits[15:8] zero. Otherwise 16 bits are sent, starting from bit15.
- R5: SCK is low outside transfers, has a period of 2*(divider+1) clocks, and gives exactly 16 or 8 rising edges per slot. MOSI never changes on a rising SCK edge.
- R6: Throughout a slot, sel equals command bits[3:0]. When no run is active, sel equals the idle pattern.
- R7: Command bit6 = 1 moves straight to the next slot's select pattern. With bit6 = 0, exactly one clock of idle pattern separates two slots.
- R8: Command bit5 = 1 adds exactly 8 clocks after that slot's transfer.
- R9: The completed pointer takes the index of each slot as it finishes. Done is set when the last-pointer slot finishes. irq = done AND interrupt enable.
- R10: Done stays set until the host writes status with bit0 = 1. Writing 0 there has no effect.
- R11: Clearing enable mid-run lets the current slot finish. The engine then idles, with the completed pointer at that slot and done left clear.
- R12: Only a control write with bit0 = 1 in IDLE starts a run. Such a write during a run, or a control write with bit0 = 0, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host write word address |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | 6 | Host read word address |
| host_rdata | output | 16 | Host read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel | output | 4 | Peripheral select levels |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps every first-slot value against runs of 1, 4 and 16 slots, so every wrap position is covered. After each run it compares all sixteen incoming words with an arithmetic model. An off-by-one in the walk would either write a slot next to the range or drop the last one. A wrong wrap would touch slots outside the range. The bench counts SCK rising edges and measures the SCK period across divider settings, which exposes an 8-bit length that shifts the wrong half or a divider off by one. It times a run with and without the pause bit and counts idle-pattern cycles with and without the keep bit. Separate cases cover stopping mid-run, start writes issued while busy, and write-one-to-clear. A design that restarted, set done on a stop, or cleared done on a zero write would show a wrong completed pointer, edge count or status.

// File: rtl/spq_pkg.sv
`timescale 1ns/1ps
package spq_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LOAD  = 3'd1,
        S_SHIFT = 3'd2,
        S_PAUSE = 3'd3,
        S_GAP   = 3'd4
    } spq_state_e;

    // command byte field positions
    localparam int CMD_LEN8 = 4;
    localparam int CMD_DLY  = 5;
    localparam int CMD_KEEP = 6;

    // register offsets inside the register region
    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_PTR  = 3'd1;
    localparam logic [2:0] REG_DIV  = 3'd2;
    localparam logic [2:0] REG_IDLE = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;
endpackage

// File: rtl/spq_store.sv
`timescale 1ns/1ps
module spq_store #(
    parameter int ENTRIES = 16,
    parameter int DIV_W   = 8,
    parameter int CS_W    = 4,
    localparam int PW     = $clog2(ENTRIES),
    localparam int AW     = PW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [15:0]      host_wdata,
    input  logic [AW-1:0]    host_raddr,
    output logic [15:0]      host_rdata,
    input  logic [PW-1:0]    eng_idx,
    output logic [7:0]       eng_cmd,
    output logic [15:0]      eng_tx,
    input  logic             eng_rx_we,
    input  logic [15:0]      eng_rx,
    input  logic             eng_done_set,
    output logic             cfg_en,
    output logic             cfg_irq_en,
    output logic [PW-1:0]    cfg_first,
    output logic [PW-1:0]    cfg_last,
    output logic [DIV_W-1:0] cfg_div,
    output logic [CS_W-1:0]  cfg_idle,
    output logic             go,
    output logic             done_flag,
    output logic [PW-1:0]    cpt_idx
);
    import spq_pkg::*;

    logic [7:0]  cmd_mem [ENTRIES];
    logic [15:0] tx_mem  [ENTRIES];
    logic [15:0] rx_mem  [ENTRIES];

    logic [1:0]    w_reg, r_reg;
    logic [PW-1:0] w_idx, r_idx;
    logic [2:0]    w_sub, r_sub;
    logic          reg_we;

    assign w_reg  = host_addr[AW-1 -: 2];
    assign w_idx  = host_addr[PW-1:0];
    assign w_sub  = host_addr[2:0];
    assign r_reg  = host_raddr[AW-1 -: 2];
    assign r_idx  = host_raddr[PW-1:0];
    assign r_sub  = host_raddr[2:0];
    assign reg_we = host_we && (w_reg == 2'd3);
    assign go     = reg_we && (w_sub == REG_CTRL) && host_wdata[0];

    always_ff @(posedge clk) begin
        if (host_we && w_reg == 2'd0) cmd_mem[w_idx] <= host_wdata[7:0];
        if (host_we && w_reg == 2'd1) tx_mem[w_idx]  <= host_wdata;
        if (eng_rx_we)                rx_mem[eng_idx] <= eng_rx;
    end

    assign eng_cmd = cmd_mem[eng_idx];
    assign eng_tx  = tx_mem[eng_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en     <= 1'b0;
            cfg_irq_en <= 1'b0;
            cfg_first  <= '0;
            cfg_last   <= '0;
            cfg_div    <= '0;
            cfg_idle   <= '1;
            done_flag  <= 1'b0;
            cpt_idx    <= '0;
        end else begin
            if (reg_we && w_sub == REG_CTRL) begin
                cfg_en     <= host_wdata[0];
                cfg_irq_en <= host_wdata[1];
            end
            if (reg_we && w_sub == REG_PTR) begin
                cfg_first <= host_wdata[PW-1:0];
                cfg_last  <= host_wdata[PW +: PW];
            end
            if (reg_we && w_sub == REG_DIV)  cfg_div  <= host_wdata[DIV_W-1:0];
            if (reg_we && w_sub == REG_IDLE) cfg_idle <= host_wdata[CS_W-1:0];
            if (eng_done_set)
                done_flag <= 1'b1;
            else if (reg_we && w_sub == REG_STAT && host_wdata[0])
                done_flag <= 1'b0;
            if (eng_rx_we) cpt_idx <= eng_idx;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (r_reg)
            2'd0: host_rdata[7:0] = cmd_mem[r_idx];
            2'd1: host_rdata      = tx_mem[r_idx];
            2'd2: host_rdata      = rx_mem[r_idx];
            default: begin
                if (r_sub == REG_CTRL) host_rdata[1:0] = {cfg_irq_en, cfg_en};
                if (r_sub == REG_PTR) begin
                    host_rdata[PW-1:0]  = cfg_first;
                    host_rdata[PW +: PW] = cfg_last;
                end
                if (r_sub == REG_DIV)  host_rdata[DIV_W-1:0] = cfg_div;
                if (r_sub == REG_IDLE) host_rdata[CS_W-1:0]  = cfg_idle;
                if (r_sub == REG_STAT) begin
                    host_rdata[0]      = done_flag;
                    host_rdata[4 +: PW] = cpt_idx;
                end
            end
        endcase
    end
endmodule

// File: rtl/spq_shift.sv
`timescale 1ns/1ps
module spq_shift #(
    parameter int DIV_W   = 8,
    parameter int WORD_W  = 16,
    localparam int SHORT_W = WORD_W / 2,
    localparam int BW      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              len8,
    input  logic [WORD_W-1:0] tx,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [WORD_W-1:0] rx,
    output logic              last
);
    logic              busy;
    logic [DIV_W-1:0]  cnt;
    logic [BW-1:0]     bits_left;
    logic [WORD_W-1:0] sreg;
    logic              tick;

    assign tick = busy && (cnt == div);
    assign last = tick && sclk && (bits_left == '0);
    assign mosi = sreg[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sclk      <= 1'b0;
            cnt       <= '0;
            bits_left <= '0;
            sreg      <= '0;
            rx        <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            sclk      <= 1'b0;
            cnt       <= '0;
            bits_left <= len8 ? BW'(SHORT_W - 1) : BW'(WORD_W - 1);
            sreg      <= len8 ? {tx[SHORT_W-1:0], {SHORT_W{1'b0}}} : tx;
            rx        <= '0;
        end else if (tick) begin
            cnt <= '0;
            if (!sclk) begin
                sclk <= 1'b1;
                rx   <= {rx[WORD_W-2:0], miso};
            end else begin
                sclk <= 1'b0;
                if (bits_left == '0) begin
                    busy <= 1'b0;
                end else begin
                    bits_left <= bits_left - 1'b1;
                    sreg      <= {sreg[WORD_W-2:0], 1'b0};
                end
            end
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spq_master.sv
`timescale 1ns/1ps
module spq_master #(
    parameter int ENTRIES   = 16,
    parameter int DIV_W     = 8,
    parameter int CS_W      = 4,
    parameter int DELAY_CYC = 8,
    localparam int PW       = $clog2(ENTRIES),
    localparam int AW       = PW + 2,
    localparam int DCW      = $clog2(DELAY_CYC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [15:0]     host_wdata,
    input  logic [AW-1:0]   host_raddr,
    output logic [15:0]     host_rdata,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [CS_W-1:0] sel,
    output logic            irq
);
    import spq_pkg::*;

    spq_state_e       state, state_nx, after;
    logic [PW-1:0]    cur;
    logic [7:0]       cmd_q;
    logic [DCW-1:0]   dcnt;
    logic [7:0]       eng_cmd;
    logic [15:0]      eng_tx, sh_rx;
    logic             sh_start, sh_last, rx_we, done_set, slot_end, is_last;
    logic             cfg_en, cfg_irq_en, go, done_flag;
    logic [PW-1:0]    cfg_first, cfg_last, cpt_idx;
    logic [DIV_W-1:0] cfg_div;
    logic [CS_W-1:0]  cfg_idle;
    logic             unused_cmd_bits;

    assign unused_cmd_bits = ^{eng_cmd[7:CMD_DLY], cmd_q[7], cmd_q[CMD_LEN8:CS_W]};

    spq_store #(.ENTRIES(ENTRIES), .DIV_W(DIV_W), .CS_W(CS_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .eng_idx(cur), .eng_cmd(eng_cmd), .eng_tx(eng_tx),
        .eng_rx_we(rx_we), .eng_rx(sh_rx), .eng_done_set(done_set),
        .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en), .cfg_first(cfg_first),
        .cfg_last(cfg_last), .cfg_div(cfg_div), .cfg_idle(cfg_idle),
        .go(go), .done_flag(done_flag), .cpt_idx(cpt_idx)
    );

    spq_shift #(.DIV_W(DIV_W), .WORD_W(16)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start),
        .len8(eng_cmd[CMD_LEN8]), .tx(eng_tx), .div(cfg_div), .miso(miso),
        .sclk(sclk), .mosi(mosi), .rx(sh_rx), .last(sh_last)
    );

    assign is_last  = (cur == cfg_last);
    assign slot_end = (state == S_SHIFT && sh_last && !cmd_q[CMD_DLY]) ||
                      (state == S_PAUSE && dcnt == DCW'(DELAY_CYC - 1));
    assign irq      = done_flag && cfg_irq_en;

    // next-state selection
    always_comb begin
        after    = (is_last || !cfg_en) ? S_IDLE
                 : (cmd_q[CMD_KEEP] ? S_LOAD : S_GAP);
        state_nx = state;
        unique case (state)
            S_IDLE:  if (go) state_nx = S_LOAD;
            S_LOAD:  state_nx = S_SHIFT;
            S_SHIFT: if (sh_last) state_nx = cmd_q[CMD_DLY] ? S_PAUSE : after;
            S_PAUSE: if (slot_end) state_nx = after;
            S_GAP:   state_nx = S_LOAD;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // slot pointer, latched command and pause counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            cmd_q <= '0;
            dcnt  <= '0;
        end else begin
            if (state == S_IDLE && go)                 cur <= cfg_first;
            else if (slot_end && !is_last && cfg_en)   cur <= cur + 1'b1;
            if (state == S_LOAD)                       cmd_q <= eng_cmd;
            dcnt <= (state == S_PAUSE) ? dcnt + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        sel      = cfg_idle;
        sh_start = 1'b0;
        rx_we    = 1'b0;
        unique case (state)
            S_LOAD: begin
                sel      = eng_cmd[CS_W-1:0];
                sh_start = 1'b1;
            end
            S_SHIFT: begin
                sel   = cmd_q[CS_W-1:0];
                rx_we = sh_last;
            end
            S_PAUSE: sel = cmd_q[CS_W-1:0];
            default: sel = cfg_idle;
        endcase
        done_set = slot_end && is_last;
    end
endmodule

// File: rtl/spq_check.sv
`timescale 1ns/1ps
module spq_check #(
    parameter int PW = 4,
    parameter int AW = 6,
    parameter int CS_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input spq_pkg::spq_state_e st,
    input logic                sclk,
    input logic                mosi,
    input logic [CS_W-1:0]     sel,
    input logic                done_flag,
    input logic                irq,
    input logic                host_we,
    input logic [AW-1:0]       host_addr,
    input logic                host_wd0,
    input logic                rx_we,
    input logic [PW-1:0]       cpt_idx
);
    import spq_pkg::*;

    logic clr_req;
    assign clr_req = host_we && host_addr[AW-1 -: 2] == 2'd3 &&
                     host_addr[2:0] == REG_STAT && host_wd0;

    p_sclk_low_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !sclk);

    p_mosi_steady_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    p_sel_steady_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT && $past(st) == S_SHIFT) |-> $stable(sel));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !clr_req) |=> done_flag);

    p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

    p_cpt_moves_on_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_we |=> $stable(cpt_idx));
endmodule

bind spq_master spq_check #(.PW(PW), .AW(AW), .CS_W(CS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(state), .sclk(sclk), .mosi(mosi),
    .sel(sel), .done_flag(done_flag), .irq(irq), .host_we(host_we),
    .host_addr(host_addr), .host_wd0(host_wdata[0]), .rx_we(rx_we),
    .cpt_idx(cpt_idx)
);

// File: tb/sim_spq_master.sv
`timescale 1ns/1ps
module sim_spq_master;
    logic        clk = 1'b0, rst_n = 1'b0, host_we = 1'b0, inv = 1'b0;
    logic [5:0]  host_addr = '0, host_raddr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        sclk, mosi, irq, miso;
    logic [3:0]  sel;

    assign miso = mosi ^ inv;

    spq_master u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .sel(sel), .irq(irq)
    );

    always #2 clk = ~clk;

    int vec = 0, bad = 0;
    int rises = 0, last_per = 0, last_rise_t = 0, idle_cyc = 0, sel_bad = 0, cyc_all = 0;
    bit run_active = 0, chk_sel = 0;
    logic sclk_p = 1'b0;
    logic [3:0] idle_pat_b = 4'hF;

    always @(posedge clk) begin
        #1;
        cyc_all++;
        if (sclk && !sclk_p) begin
            rises++;
            last_per    = cyc_all - last_rise_t;
            last_rise_t = cyc_all;
            if (chk_sel && $countones(sel) != 3) sel_bad++;
        end
        sclk_p = sclk;
        if (run_active && !irq && sel == idle_pat_b) idle_cyc++;
        if (cyc_all > 190000) begin
            bad++;
            $display("FAIL watchdog: run hung, got %0d cycles expected under 190000", cyc_all);
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [7:0] mk_cmd(input int i, input bit keep, input bit dly, input bit l8);
        logic [3:0] one;
        one = 4'b0001 << (i % 4);
        return {1'b0, keep, dly, l8, ~one};
    endfunction

    function automatic logic [15:0] exp_rx(input logic [15:0] tx, input bit l8, input bit iv);
        if (l8) return {8'h00, tx[7:0] ^ {8{iv}}};
        return tx ^ {16{iv}};
    endfunction

    task automatic run(input int s, input int e, output int t);
        wr(6'h31, {8'h00, e[3:0], s[3:0]});
        rises = 0; idle_cyc = 0;
        wr(6'h30, 16'h0003);
        run_active = 1;
        t = 0;
        while (!irq && t < 20000) begin
            @(negedge clk);
            t++;
        end
        run_active = 0;
        wr(6'h34, 16'h0001);
    endtask

    logic [15:0] txv [16];
    logic [15:0] model [16];
    bit          l8v [16];
    logic [15:0] r;
    int          t0, t1, nexp;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sel", int'(sel), 'hF);
        check("R1 sclk", int'(sclk), 0);
        check("R1 irq", int'(irq), 0);
        rd(6'h34, r); check("R1 status", int'(r), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // program queue: odd slots 8-bit, no keep, no pause
        for (int i = 0; i < 16; i++) begin
            l8v[i] = (i % 2) == 1;
            wr(6'(i), {8'h00, mk_cmd(i, 0, 0, l8v[i])});
        end
        wr(6'h32, 16'h0000);
        // R2: register map readback
        rd(6'h05, r); check("R2 cmd readback", int'(r), int'({8'h00, mk_cmd(5, 0, 0, 1)}));
        wr(6'h31, 16'h00C3);
        rd(6'h31, r); check("R2 ptr readback", int'(r), 'hC3);
        rd(6'h33, r); check("R2 idle readback", int'(r), 'hF);

        // full pass to initialise the model
        for (int i = 0; i < 16; i++) begin
            txv[i] = 16'h3C5A ^ 16'(i * 16'h0B17);
            wr(6'h10 + 6'(i), txv[i]);
        end
        inv = 1'b0;
        chk_sel = 1;
        run(0, 15, t0);
        for (int i = 0; i < 16; i++) begin
            model[i] = exp_rx(txv[i], l8v[i], 0);
            rd(6'h20 + 6'(i), r); check("R4 initial pass", int'(r), int'(model[i]));
        end

        // sweep of first pointer against lengths 1, 4 and 16 (wrap covered)
        for (int run_i = 0; run_i < 48; run_i++) begin
            int s, d, e, tt;
            s = run_i / 3;
            d = (run_i % 3 == 0) ? 0 : ((run_i % 3 == 1) ? 3 : 15);
            e = (s + d) % 16;
            inv = run_i[0];
            for (int i = 0; i < 16; i++) begin
                txv[i] = 16'hA5C3 ^ 16'(run_i * 16'h1357) ^ 16'(i * 16'h0F1D);
                wr(6'h10 + 6'(i), txv[i]);
            end
            nexp = 0;
            for (int k = 0; k <= d; k++) begin
                int idx;
                idx = (s + k) % 16;
                model[idx] = exp_rx(txv[idx], l8v[idx], inv);
                nexp += l8v[idx] ? 8 : 16;
            end
            run(s, e, tt);
            for (int i = 0; i < 16; i++) begin
                rd(6'h20 + 6'(i), r);
                check("R3/R4 slot word after sweep run", int'(r), int'(model[i]));
            end
            rd(6'h34, r); check("R9 completed pointer", int'(r[7:4]), e);
            check("R5 rising edge count", rises, nexp);
            check("R7 idle cycles without keep", idle_cyc, d);
        end
        check("R6 select pattern at SCK rises", sel_bad, 0);
        chk_sel = 0;

        // R5: divider sweep on a single 16-bit slot
        for (int dv = 1; dv < 6; dv++) begin
            int tt;
            wr(6'h32, 16'(dv));
            run(0, 0, tt);
            check("R5 SCK period", last_per, 2 * (dv + 1));
            check("R5 edges per 16-bit slot", rises, 16);
        end
        wr(6'h32, 16'h0000);

        // R7: keep bit, R8: pause bit
        for (int i = 0; i < 3; i++) wr(6'(i), {8'h00, mk_cmd(i, 1, 0, 0)});
        run(0, 2, t0);
        check("R7 no idle cycles with keep", idle_cyc, 0);
        for (int i = 0; i < 3; i++) wr(6'(i), {8'h00, mk_cmd(i, 0, 0, 0)});
        run(0, 2, t0);
        check("R7 one idle cycle per gap", idle_cyc, 2);
        for (int i = 0; i < 3; i++) wr(6'(i), {8'h00, mk_cmd(i, 0, 1, 0)});
        run(0, 2, t1);
        check("R8 pause adds 8 clocks per slot", t1 - t0, 24);

        // R9: interrupt gated by its enable; R10: write-one-to-clear
        wr(6'h31, 16'h0000);
        wr(6'h30, 16'h0001);
        nexp = 0;
        r = 0;
        while (r[0] == 1'b0 && nexp < 5000) begin
            @(negedge clk); nexp++;
            rd(6'h34, r);
        end
        check("R9 done with interrupt disabled", int'(r[0]), 1);
        check("R9 irq masked", int'(irq), 0);
        wr(6'h34, 16'h0000);
        rd(6'h34, r); check("R10 zero write keeps done", int'(r[0]), 1);
        wr(6'h34, 16'h0001);
        rd(6'h34, r); check("R10 one write clears done", int'(r[0]), 0);

        // R11: stop mid-run
        for (int i = 0; i < 8; i++) wr(6'(i), {8'h00, mk_cmd(i, 0, 0, 0)});
        wr(6'h32, 16'h0003);
        wr(6'h31, 16'h0070);
        rises = 0;
        wr(6'h30, 16'h0003);
        while (rises < 20) @(negedge clk);
        wr(6'h30, 16'h0002);
        repeat (400) @(negedge clk);
        check("R11 no irq after stop", int'(irq), 0);
        rd(6'h34, r); check("R11 completed pointer kept", int'(r[7:4]), 1);
        check("R11 done not set", int'(r[0]), 0);
        check("R11 current slot finished", rises, 32);
        check("R6 idle pattern after stop", int'(sel), 'hF);

        // R12: start write during a run is ignored
        wr(6'h31, 16'h0030);
        rises = 0;
        wr(6'h30, 16'h0003);
        while (rises < 20) @(negedge clk);
        wr(6'h30, 16'h0003);
        nexp = 0;
        while (!irq && nexp < 5000) begin @(negedge clk); nexp++; end
        check("R12 busy start ignored edges", rises, 64);
        rd(6'h34, r); check("R12 busy start ignored pointer", int'(r[7:4]), 3);
        wr(6'h34, 16'h0001);
        rises = 0;
        wr(6'h30, 16'h0002);
        repeat (50) @(negedge clk);
        check("R12 zero enable write starts nothing", rises, 0);

        // R6: host idle pattern
        wr(6'h33, 16'h000A);
        @(negedge clk);
        check("R6 programmed idle pattern", int'(sel), 'hA);

        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule